// File: doc/BRIEF.md
# Cascade Interlock Controller

This block is the per-slice sequencing logic that lets several buffer slices work as one array in lockstep, with no glue logic between them. Each slice decides for itself, while master reset is held, whether it leads its row or follows it. A leader has its chain input tied LOW. A follower takes its chain input from the completion output of the slice just above it in priority. After that, a shared "store the word" request makes each slice clear its input register in turn. A shared "fetch a word" request makes each slice raise its output-valid flag in turn. The leader acts at once. Each follower waits until the slice above it has finished, so completion moves down the chain one slice per clock. The data path is outside this block.

The input side is a three-state machine. IN_IDLE moves to IN_PEND when a store request is sampled. IN_PEND moves to IN_DONE in the cycle in which the slice may clear its register: at once for a leader, or once the chain input is LOW for a follower. IN_DONE returns to IN_IDLE when the store request is released. The output side is also a three-state machine. OUT_IDLE moves to OUT_REQ on a parallel or serial fetch request. OUT_REQ moves to OUT_FULL at once for a leader, or once the upstream flag is seen HIGH for a follower. OUT_FULL returns to OUT_IDLE when the consumer reports that the word has been taken. A LOW master reset sends both machines to their idle states from any state.

Top module: `cascade_interlock`

## Requirements
- R1: While `mr_n` is LOW, `is_master` is updated at each clock edge to the inverse of `chain_in_n`. While `mr_n` is HIGH, `is_master` holds its value. After `rst_n`, `is_master` is 0.
- R2: At a clock edge with `mr_n` LOW, both machines go to idle, so `in_done_n` is 1 and `set_out` is 0 in the following cycle. `init_in` is 0 in any cycle in which `mr_n` is LOW. `rst_n` LOW gives the same idle state.
- R3: A leader (`is_master`=1) that samples `load_req_n` LOW while in IN_IDLE drives `init_in` HIGH for exactly the next cycle.
- R4: A follower in IN_PEND drives `init_in` HIGH only in a cycle in which `chain_in_n` is LOW, and does so combinationally in that same cycle.
- R5: After `init_in`, `in_done_n` is LOW from the next cycle until an edge samples `load_req_n` HIGH. While `load_req_n` stays LOW, `init_in` does not fire again.
- R6: `pull_par` HIGH or `pull_ser_n` LOW sampled in OUT_IDLE starts a fetch. For a leader, `set_out` rises in the cycle after the second clock edge, counted from the edge that sampled the request.
- R7: A follower in OUT_REQ keeps `set_out` LOW until an edge samples `up_full` HIGH, and raises it in the next cycle.
- R8: `set_out` stays HIGH, and fetch requests have no effect, until an edge samples `out_drain` HIGH. `set_out` is LOW in the cycle after that edge.
- R9: In a chain of three slices, the `init_in` pulses and the `set_out` rises appear in priority order, one cycle apart. The last slice's flag rises only after both upstream flags are HIGH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active LOW |
| mr_n | input | 1 | Master reset, active LOW, synchronous; role is captured while LOW |
| chain_in_n | input | 1 | Chain input: tied LOW on a leader, upstream `in_done_n` on a follower |
| load_req_n | input | 1 | Store-word request, active LOW |
| pull_par | input | 1 | Parallel fetch request, active HIGH |
| pull_ser_n | input | 1 | Serial fetch request, active LOW |
| up_full | input | 1 | Upstream `set_out`; ignored by a leader |
| out_drain | input | 1 | Output word taken; clears the flag |
| init_in | output | 1 | Command to clear the input register |
| in_done_n | output | 1 | LOW once the input register has been cleared for the current request |
| set_out | output | 1 | Output-valid flag |
| is_master | output | 1 | Latched role: 1 for leader |

## Verification
Two collisions matter here. A LOW master reset can arrive in the same cycle as a store request that is still pending, and reset must win: no `init_in`, and both machines go to idle. A drain can land in the same cycle as a fresh fetch request while the flag is HIGH, and the drain must win: the flag drops, and the request is only taken on the following edge. Random stimulus from a fixed seed asserts reset, store, fetch and drain with overlapping probabilities. Directed steps force each collision, and every output of the three chained slices is compared each cycle with a cycle model held in the bench.

// File: rtl/cascade_interlock_pkg.sv
`timescale 1ns/1ps
package cascade_interlock_pkg;
    typedef enum logic [1:0] {
        IN_IDLE = 2'd0,
        IN_PEND = 2'd1,
        IN_DONE = 2'd2
    } in_st_t;

    typedef enum logic [1:0] {
        OUT_IDLE = 2'd0,
        OUT_REQ  = 2'd1,
        OUT_FULL = 2'd2
    } out_st_t;
endpackage

// File: rtl/cil_role_latch.sv
`timescale 1ns/1ps
module cil_role_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic mr_n,
    input  logic chain_in_n,
    output logic master
);
    logic master_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            master_q <= 1'b0;
        else if (!mr_n)
            master_q <= ~chain_in_n;
    end

    assign master = master_q;

    p_role_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mr_n |=> $stable(master_q));
    p_role_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !mr_n |=> (master_q == ~$past(chain_in_n)));
endmodule

// File: rtl/cil_in_seq.sv
`timescale 1ns/1ps
module cil_in_seq
    import cascade_interlock_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mr_n,
    input  logic master,
    input  logic chain_in_n,
    input  logic load_req_n,
    output logic init_in,
    output logic done_n
);
    in_st_t st, st_nxt;
    logic   may_clear;

    assign may_clear = master | ~chain_in_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st <= IN_IDLE;
        else
            st <= st_nxt;
    end

    always_comb begin
        st_nxt = st;
        if (!mr_n) begin
            st_nxt = IN_IDLE;
        end else begin
            unique case (st)
                IN_IDLE: if (!load_req_n) st_nxt = IN_PEND;
                IN_PEND: if (may_clear)   st_nxt = IN_DONE;
                IN_DONE: if (load_req_n)  st_nxt = IN_IDLE;
                default: st_nxt = IN_IDLE;
            endcase
        end
    end

    always_comb begin
        init_in = 1'b0;
        done_n  = 1'b1;
        unique case (st)
            IN_IDLE: ;
            IN_PEND: init_in = may_clear & mr_n;
            IN_DONE: done_n  = 1'b0;
            default: ;
        endcase
    end

    p_init_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        init_in |=> !init_in);
    p_done_after_init_r5: assert property (@(posedge clk) disable iff (!rst_n)
        init_in |=> !done_n);
    p_reset_input_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !mr_n |=> done_n);
    p_no_init_in_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !mr_n |-> !init_in);
endmodule

// File: rtl/cil_out_seq.sv
`timescale 1ns/1ps
module cil_out_seq
    import cascade_interlock_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mr_n,
    input  logic master,
    input  logic pull_par,
    input  logic pull_ser_n,
    input  logic up_full,
    input  logic out_drain,
    output logic set_out
);
    out_st_t st, st_nxt;
    logic    want;

    assign want = pull_par | ~pull_ser_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st <= OUT_IDLE;
        else
            st <= st_nxt;
    end

    always_comb begin
        st_nxt = st;
        if (!mr_n) begin
            st_nxt = OUT_IDLE;
        end else begin
            unique case (st)
                OUT_IDLE: if (want)              st_nxt = OUT_REQ;
                OUT_REQ:  if (master || up_full) st_nxt = OUT_FULL;
                OUT_FULL: if (out_drain)         st_nxt = OUT_IDLE;
                default:  st_nxt = OUT_IDLE;
            endcase
        end
    end

    always_comb begin
        set_out = 1'b0;
        unique case (st)
            OUT_IDLE: ;
            OUT_REQ:  ;
            OUT_FULL: set_out = 1'b1;
            default:  ;
        endcase
    end

    p_flag_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (set_out && out_drain) |=> !set_out);
    p_flag_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(set_out) && !master) |-> $past(up_full));
    p_reset_output_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !mr_n |=> !set_out);
endmodule

// File: rtl/cascade_interlock.sv
`timescale 1ns/1ps
module cascade_interlock (
    input  logic clk,
    input  logic rst_n,
    input  logic mr_n,
    input  logic chain_in_n,
    input  logic load_req_n,
    input  logic pull_par,
    input  logic pull_ser_n,
    input  logic up_full,
    input  logic out_drain,
    output logic init_in,
    output logic in_done_n,
    output logic set_out,
    output logic is_master
);
    logic master;

    cil_role_latch u_role (
        .clk        (clk),
        .rst_n      (rst_n),
        .mr_n       (mr_n),
        .chain_in_n (chain_in_n),
        .master     (master)
    );

    cil_in_seq u_in (
        .clk        (clk),
        .rst_n      (rst_n),
        .mr_n       (mr_n),
        .master     (master),
        .chain_in_n (chain_in_n),
        .load_req_n (load_req_n),
        .init_in    (init_in),
        .done_n     (in_done_n)
    );

    cil_out_seq u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .mr_n       (mr_n),
        .master     (master),
        .pull_par   (pull_par),
        .pull_ser_n (pull_ser_n),
        .up_full    (up_full),
        .out_drain  (out_drain),
        .set_out    (set_out)
    );

    assign is_master = master;

    p_leader_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(set_out) && master) |-> $past(mr_n));
endmodule

// File: tb/cascade_interlock_tb.sv
`timescale 1ns/1ps
module cascade_interlock_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mr_n = 1'b1, load_req_n = 1'b1, pull_par = 1'b0, pull_ser_n = 1'b1, out_drain = 1'b0;
    logic init_w [3];
    logic done_w [3];
    logic set_w  [3];
    logic mst_w  [3];

    int n_chk = 0, n_fail = 0, cyc = 0;
    int m_role [3], m_ist [3], m_ost [3];
    int first_init [3], n_init [3], rise_cyc [3];
    logic prev_set [3];

    always #5 clk = ~clk;

    cascade_interlock u_dut (
        .clk(clk), .rst_n(rst_n), .mr_n(mr_n), .chain_in_n(1'b0),
        .load_req_n(load_req_n), .pull_par(pull_par), .pull_ser_n(pull_ser_n),
        .up_full(1'b0), .out_drain(out_drain),
        .init_in(init_w[0]), .in_done_n(done_w[0]), .set_out(set_w[0]), .is_master(mst_w[0]));
    cascade_interlock u_s1 (
        .clk(clk), .rst_n(rst_n), .mr_n(mr_n), .chain_in_n(done_w[0]),
        .load_req_n(load_req_n), .pull_par(pull_par), .pull_ser_n(pull_ser_n),
        .up_full(set_w[0]), .out_drain(out_drain),
        .init_in(init_w[1]), .in_done_n(done_w[1]), .set_out(set_w[1]), .is_master(mst_w[1]));
    cascade_interlock u_s2 (
        .clk(clk), .rst_n(rst_n), .mr_n(mr_n), .chain_in_n(done_w[1]),
        .load_req_n(load_req_n), .pull_par(pull_par), .pull_ser_n(pull_ser_n),
        .up_full(set_w[1]), .out_drain(out_drain),
        .init_in(init_w[2]), .in_done_n(done_w[2]), .set_out(set_w[2]), .is_master(mst_w[2]));

    function automatic int f_done_n(int k);
        return (m_ist[k] == 2) ? 0 : 1;
    endfunction
    function automatic int f_chain_n(int k);
        return (k == 0) ? 0 : f_done_n(k - 1);
    endfunction
    function automatic int f_upfull(int k);
        return (k == 0) ? 0 : ((m_ost[k-1] == 2) ? 1 : 0);
    endfunction
    function automatic int f_init(int k, logic mr);
        return (m_ist[k] == 1 && (m_role[k] != 0 || f_chain_n(k) == 0) && mr) ? 1 : 0;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
        end
    endtask

    task automatic step(input logic mr, input logic ld, input logic pp, input logic ps, input logic dr);
        int nr [3], ni [3], no [3];
        mr_n = mr; load_req_n = ld; pull_par = pp; pull_ser_n = ps; out_drain = dr;
        #1;
        for (int k = 0; k < 3; k++) begin
            chk((k == 0) ? "R3 init_in" : "R4 init_in", int'(init_w[k]), f_init(k, mr));
            chk("R5 in_done_n", int'(done_w[k]), f_done_n(k));
            chk((k == 0) ? "R6 set_out" : "R7 set_out", int'(set_w[k]), (m_ost[k] == 2) ? 1 : 0);
            chk("R1 is_master", int'(mst_w[k]), m_role[k]);
            if (init_w[k]) begin
                n_init[k]++;
                if (first_init[k] < 0) first_init[k] = cyc;
            end
            if (set_w[k] && !prev_set[k] && rise_cyc[k] < 0) rise_cyc[k] = cyc;
            prev_set[k] = set_w[k];
        end
        for (int k = 0; k < 3; k++) begin
            nr[k] = m_role[k]; ni[k] = m_ist[k]; no[k] = m_ost[k];
            if (!mr) begin
                nr[k] = (f_chain_n(k) == 0) ? 1 : 0;
                ni[k] = 0; no[k] = 0;
            end else begin
                case (m_ist[k])
                    0: if (!ld) ni[k] = 1;
                    1: if (m_role[k] != 0 || f_chain_n(k) == 0) ni[k] = 2;
                    default: if (ld) ni[k] = 0;
                endcase
                case (m_ost[k])
                    0: if (pp || !ps) no[k] = 1;
                    1: if (m_role[k] != 0 || f_upfull(k) != 0) no[k] = 2;
                    default: if (dr) no[k] = 0;
                endcase
            end
        end
        for (int k = 0; k < 3; k++) begin
            m_role[k] = nr[k]; m_ist[k] = ni[k]; m_ost[k] = no[k];
        end
        cyc++;
        @(negedge clk);
    endtask

    task automatic clear_marks();
        for (int k = 0; k < 3; k++) begin
            first_init[k] = -1; n_init[k] = 0; rise_cyc[k] = -1;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int c0;
        for (int k = 0; k < 3; k++) begin
            m_role[k] = 0; m_ist[k] = 0; m_ost[k] = 0; prev_set[k] = 1'b0;
        end
        clear_marks();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
        for (int k = 0; k < 3; k++) begin
            chk("R2 reset set_out", int'(set_w[k]), 0);
            chk("R2 reset in_done_n", int'(done_w[k]), 1);
            chk("R1 reset is_master", int'(mst_w[k]), 0);
        end
        @(negedge clk);

        // Role capture
        step(0, 1, 0, 1, 0);
        step(0, 1, 0, 1, 0);
        step(1, 1, 0, 1, 0);
        chk("R1 leader role", int'(mst_w[0]), 1);
        chk("R1 slave1 role", int'(mst_w[1]), 0);
        chk("R1 slave2 role", int'(mst_w[2]), 0);

        // Input ripple
        clear_marks();
        c0 = cyc;
        step(1, 0, 0, 1, 0);
        repeat (6) step(1, 0, 0, 1, 0);
        chk("R3 leader init cycle", first_init[0], c0 + 1);
        chk("R9 init order s1", first_init[1], first_init[0] + 1);
        chk("R9 init order s2", first_init[2], first_init[1] + 1);
        for (int k = 0; k < 3; k++) chk("R5 single init", n_init[k], 1);
        step(1, 1, 0, 1, 0);
        step(1, 1, 0, 1, 0);

        // Output ripple
        clear_marks();
        c0 = cyc;
        step(1, 1, 1, 1, 0);
        repeat (5) step(1, 1, 0, 1, 0);
        chk("R6 leader flag cycle", rise_cyc[0], c0 + 2);
        chk("R7 slave1 flag cycle", rise_cyc[1], c0 + 3);
        chk("R9 last flag after upstream", rise_cyc[2], c0 + 4);
        // Requests while full have no effect
        step(1, 1, 1, 0, 0);
        step(1, 1, 1, 0, 0);
        for (int k = 0; k < 3; k++) chk("R8 held while full", int'(set_w[k]), 1);
        step(1, 1, 0, 1, 1);
        for (int k = 0; k < 3; k++) chk("R8 cleared by drain", int'(set_w[k]), 0);
        step(1, 1, 0, 1, 0);
        step(1, 1, 0, 1, 0);

        // Collision: drain and serial fetch in the same cycle while full
        repeat (5) step(1, 1, 0, 0, 0);
        step(1, 1, 0, 0, 1);
        chk("R8 drain wins over fetch", int'(set_w[0]), 0);
        repeat (4) step(1, 1, 0, 1, 1);

        // Collision: master reset together with a store request
        step(1, 0, 0, 1, 0);
        step(0, 0, 0, 1, 0);
        chk("R2 no init in reset", int'(init_w[0]) + int'(init_w[1]) + int'(init_w[2]), 0);
        step(0, 1, 0, 1, 0);
        step(1, 1, 0, 1, 0);

        void'($urandom(32'd2024));
        repeat (3000) begin
            logic mr, ld, pp, ps, dr;
            mr = ($urandom_range(0, 31) != 0);
            ld = ($urandom_range(0, 2) != 0);
            pp = ($urandom_range(0, 3) == 0);
            ps = ($urandom_range(0, 3) != 0);
            dr = ($urandom_range(0, 2) == 0);
            step(mr, ld, pp, ps, dr);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule